// File: doc/BRIEF.md
# Command/Data SPI Framer

This block turns a stream of tagged bytes into traffic on a write-only four-wire serial link to an e-paper panel controller. The link has a clock, a data line, an active-low chip select and a data/command select line. An upstream sequencer hands over one byte at a time through a valid/ready handshake. Each byte carries two tags: one says whether it is a command or a parameter, and a `last` flag marks the end of a run of parameters. The framer shifts each byte out most significant bit first in SPI mode 0. The data/command line is low for command bytes and high for parameter bytes.

A command byte always gets a chip-select window of its own. Parameter bytes that are not marked last keep chip select low, so a following parameter byte continues in the same window. This lets a whole image be streamed under one assertion. A parameter marked last closes the window. A command offered while a window is open is held off until the window has closed. The serial clock is the system clock divided by `2*HALF_DIV`, so `HALF_DIV` sets the link rate. For example, a 160 MHz system clock with `HALF_DIV` of 4 gives 20 MHz, and with `HALF_DIV` of 2 gives 40 MHz.

Top module: `epd_spi_framer`

## Requirements
- R1: A byte tagged as command is sent with `dc` low in a chip-select window that holds that byte alone. `cs_n` rises after its eighth bit.
- R2: A parameter byte tagged last is sent with `dc` high. `cs_n` rises after its eighth bit, so the next byte opens a new window.
- R3: A parameter byte not tagged last leaves `cs_n` low after its eighth bit. The next parameter byte is sent in the same window.
- R4: While a window is open, a command byte offered on the input sees `in_ready` low. The window is closed first, and the command is then sent in a new window.
- R5: `sclk` is low whenever `cs_n` is high. Each byte produces exactly eight rising edges of `sclk`. Bit 7 is on `mosi` at the first rising edge and bit 0 at the last.
- R6: Every phase of `sclk` lasts `HALF_DIV` clock cycles. `mosi` and `dc` stay unchanged for at least `HALF_DIV` cycles before every rising edge of `sclk`.
- R7: `in_ready` is low from the cycle a byte is accepted until its final low phase has ended. It is high only when the framer is idle or waiting inside an open window.
- R8: Between two windows, `cs_n` stays high for at least `2*HALF_DIV` clock cycles, which is one full serial clock period.
- R9: `dc` never changes while `cs_n` is low.
- R10: While `rst` is high, and in the cycle after it, `cs_n` is 1, `sclk` is 0, `dc` is 1 and `in_ready` is 1. Asserting `rst` in the middle of a byte abandons that byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Upstream byte is offered |
| in_ready | output | 1 | Framer takes the offered byte on this edge |
| in_byte | input | 8 | Byte value to send |
| in_is_cmd | input | 1 | 1 = command byte, 0 = parameter byte |
| in_last | input | 1 | Parameter byte ends the window |
| sclk | output | 1 | Serial clock, idles low |
| mosi | output | 1 | Serial data, MSB first |
| cs_n | output | 1 | Chip select, active low |
| dc | output | 1 | 0 = command, 1 = parameter |

## Verification
The hardest case to reach is a command arriving while a parameter window is still open. The upstream side has to offer the command just after an unterminated parameter byte. The framer must then refuse it, close the window with the required gap, and send it alone. The stimulus table places a command straight after a non-last parameter byte, and the bench checks that this command lands in a new window. A directed test asserts reset halfway through a byte. It then checks that the partial byte never appears and that the next byte comes out whole.

// File: rtl/epd_spi_pkg.sv
package epd_spi_pkg;

    localparam int BYTE_BITS = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_HIGH,
        ST_LOW,
        ST_BURST,
        ST_GAP
    } link_state_t;

    typedef struct packed {
        logic                 is_cmd;
        logic                 last;
        logic [BYTE_BITS-1:0] value;
    } link_byte_t;

    // A byte closes its chip-select window if it is a command or a final parameter.
    function automatic logic closes_frame(link_byte_t b);
        return b.is_cmd | b.last;
    endfunction

endpackage

// File: rtl/epd_spi_pacer.sv
module epd_spi_pacer #(
    parameter int HALF_DIV = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    input  logic long_gap,
    output logic expire
);
    localparam int LONG_LEN = 2 * HALF_DIV;
    localparam int CNT_W    = $clog2(LONG_LEN + 1) + 1;
    localparam logic [CNT_W-1:0] SHORT_LOAD = CNT_W'(HALF_DIV - 1);
    localparam logic [CNT_W-1:0] LONG_LOAD  = CNT_W'(LONG_LEN - 1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (restart) begin
            cnt <= long_gap ? LONG_LOAD : SHORT_LOAD;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign expire = (cnt == '0);
endmodule

// File: rtl/epd_spi_shifter.sv
module epd_spi_shifter
    import epd_spi_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 load,
    input  logic [BYTE_BITS-1:0] load_val,
    input  logic                 step,
    output logic                 mosi,
    output logic                 done
);
    localparam int BC_W = $clog2(BYTE_BITS + 1);

    logic [BYTE_BITS-1:0] sh;
    logic [BC_W-1:0]      sent;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh   <= '0;
            sent <= '0;
        end else if (load) begin
            sh   <= load_val;
            sent <= '0;
        end else if (step) begin
            sh   <= {sh[BYTE_BITS-2:0], 1'b0};
            sent <= sent + 1'b1;
        end
    end

    assign mosi = sh[BYTE_BITS-1];
    assign done = (sent == BC_W'(BYTE_BITS));
endmodule

// File: rtl/epd_spi_ctrl.sv
module epd_spi_ctrl
    import epd_spi_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       in_valid,
    input  link_byte_t in_item,
    output logic       in_ready,
    input  logic       expire,
    input  logic       done,
    output logic       restart,
    output logic       long_gap,
    output logic       load,
    output logic       step,
    output logic       sclk,
    output logic       cs_n,
    output logic       dc
);
    link_state_t state, nxt;
    logic        dc_q;
    logic        close_q;
    logic        accept;

    always_comb begin
        in_ready = (state == ST_IDLE) || ((state == ST_BURST) && !in_item.is_cmd);
    end

    assign accept = in_valid && in_ready;

    always_comb begin
        nxt      = state;
        restart  = 1'b0;
        long_gap = 1'b0;
        load     = 1'b0;
        step     = 1'b0;
        case (state)
            ST_IDLE: begin
                if (accept) begin
                    nxt     = ST_SETUP;
                    restart = 1'b1;
                    load    = 1'b1;
                end
            end
            ST_SETUP: begin
                if (expire) begin
                    nxt     = ST_HIGH;
                    restart = 1'b1;
                end
            end
            ST_HIGH: begin
                if (expire) begin
                    nxt     = ST_LOW;
                    restart = 1'b1;
                    step    = 1'b1;
                end
            end
            ST_LOW: begin
                if (expire) begin
                    restart = 1'b1;
                    if (!done) begin
                        nxt = ST_HIGH;
                    end else if (close_q) begin
                        nxt      = ST_GAP;
                        long_gap = 1'b1;
                    end else begin
                        nxt     = ST_BURST;
                        restart = 1'b0;
                    end
                end
            end
            ST_BURST: begin
                if (accept) begin
                    nxt     = ST_SETUP;
                    restart = 1'b1;
                    load    = 1'b1;
                end else if (in_valid) begin
                    nxt      = ST_GAP;
                    restart  = 1'b1;
                    long_gap = 1'b1;
                end
            end
            ST_GAP: begin
                if (expire) begin
                    nxt = ST_IDLE;
                end
            end
            default: nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            dc_q    <= 1'b1;
            close_q <= 1'b0;
        end else begin
            state <= nxt;
            if (load) begin
                dc_q    <= !in_item.is_cmd;
                close_q <= closes_frame(in_item);
            end else if (nxt == ST_GAP) begin
                dc_q <= 1'b1;
            end
        end
    end

    assign sclk = (state == ST_HIGH);
    assign cs_n = (state == ST_IDLE) || (state == ST_GAP);
    assign dc   = dc_q;
endmodule

// File: rtl/epd_spi_framer.sv
module epd_spi_framer
    import epd_spi_pkg::*;
#(
    parameter int HALF_DIV = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       in_valid,
    output logic       in_ready,
    input  logic [7:0] in_byte,
    input  logic       in_is_cmd,
    input  logic       in_last,
    output logic       sclk,
    output logic       mosi,
    output logic       cs_n,
    output logic       dc
);
    link_byte_t item;
    logic restart, long_gap, expire, load, step, done;

    assign item = '{is_cmd: in_is_cmd, last: in_last, value: in_byte};

    epd_spi_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .in_item  (item),
        .in_ready (in_ready),
        .expire   (expire),
        .done     (done),
        .restart  (restart),
        .long_gap (long_gap),
        .load     (load),
        .step     (step),
        .sclk     (sclk),
        .cs_n     (cs_n),
        .dc       (dc)
    );

    epd_spi_pacer #(.HALF_DIV(HALF_DIV)) u_pacer (
        .clk      (clk),
        .rst      (rst),
        .restart  (restart),
        .long_gap (long_gap),
        .expire   (expire)
    );

    epd_spi_shifter u_shift (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .load_val (item.value),
        .step     (step),
        .mosi     (mosi),
        .done     (done)
    );
endmodule

// File: rtl/epd_spi_framer_chk.sv
module epd_spi_framer_chk #(
    parameter int HALF_DIV = 4
) (
    input logic clk,
    input logic rst,
    input logic in_ready,
    input logic sclk,
    input logic mosi,
    input logic cs_n,
    input logic dc
);
    localparam int GAP_MIN = 2 * HALF_DIV;
    localparam int RUN_W   = $clog2(GAP_MIN + 1) + 1;

    logic [RUN_W-1:0] hi_run;
    logic             seen;
    logic             gap_ok;

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_run <= '0;
            seen   <= 1'b0;
        end else begin
            if (!cs_n) begin
                hi_run <= '0;
                seen   <= 1'b1;
            end else if (hi_run < RUN_W'(GAP_MIN)) begin
                hi_run <= hi_run + 1'b1;
            end
        end
    end

    assign gap_ok = !seen || (hi_run >= RUN_W'(GAP_MIN));

    assert_dc_stable_R9: assert property (@(posedge clk) disable iff (rst)
        !cs_n |=> (cs_n || $stable(dc)));

    assert_sclk_idle_R5: assert property (@(posedge clk) disable iff (rst)
        cs_n |-> !sclk);

    assert_busy_shift_R7: assert property (@(posedge clk) disable iff (rst)
        sclk |-> !in_ready);

    assert_setup_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(sclk) |-> ($stable(mosi) && $stable(dc)));

    assert_cs_gap_R8: assert property (@(posedge clk) disable iff (rst)
        $fell(cs_n) |-> gap_ok);

    assert_reset_idle_R10: assert property (@(posedge clk)
        rst |=> (cs_n && !sclk && dc && in_ready));
endmodule

bind epd_spi_framer epd_spi_framer_chk #(.HALF_DIV(HALF_DIV)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .in_ready (in_ready),
    .sclk     (sclk),
    .mosi     (mosi),
    .cs_n     (cs_n),
    .dc       (dc)
);

// File: tb/sim_epd_spi_framer.sv
`timescale 1ns/1ps
module sim_epd_spi_framer;
    localparam int H    = 3;
    localparam int NVEC = 12;
    // entry = {is_cmd, last, value}
    localparam logic [9:0] VEC [NVEC] = '{
        {1'b1, 1'b1, 8'h12},
        {1'b1, 1'b1, 8'h01},
        {1'b0, 1'b0, 8'hDF},
        {1'b0, 1'b0, 8'h01},
        {1'b0, 1'b1, 8'h02},
        {1'b1, 1'b0, 8'h3C},
        {1'b0, 1'b1, 8'h01},
        {1'b0, 1'b0, 8'hA5},
        {1'b1, 1'b1, 8'h24},
        {1'b0, 1'b0, 8'h00},
        {1'b0, 1'b0, 8'hFF},
        {1'b0, 1'b1, 8'h81}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0;
    logic [7:0] in_byte = '0;
    logic in_is_cmd = 1'b0;
    logic in_last = 1'b0;
    logic in_ready, sclk, mosi, cs_n, dc;

    int tests = 0;
    int fails = 0;

    logic [7:0] rx_byte [64];
    logic       rx_dc   [64];
    int         rx_frame[64];
    int         rx_n = 0;
    int         frame = -1;
    int         setup_viol = 0, dc_viol = 0, gap_viol = 0, ready_viol = 0, idle_viol = 0;

    always #2 clk = ~clk;

    epd_spi_framer #(.HALF_DIV(H)) u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_byte(in_byte), .in_is_cmd(in_is_cmd), .in_last(in_last),
        .sclk(sclk), .mosi(mosi), .cs_n(cs_n), .dc(dc)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic send(input logic [9:0] e);
        @(negedge clk);
        in_valid = 1'b1; in_is_cmd = e[9]; in_last = e[8]; in_byte = e[7:0];
        #1;
        while (!in_ready) begin
            @(negedge clk);
            #1;
        end
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    // Port monitor: sampled on the falling clock edge.
    initial begin
        logic p_sclk = 1'b0, p_cs = 1'b1, p_dc = 1'b1, p_mosi = 1'b0;
        int low_run = 0, mosi_run = 0, dc_run = 0, hi_run = 0, bits = 0;
        logic [7:0] acc = '0;
        bit seen = 0;
        forever begin
            @(negedge clk);
            if (!rst) begin
                if (sclk && in_ready) ready_viol++;
                if (cs_n && sclk) idle_viol++;
                if (!cs_n && !p_cs && dc != p_dc) dc_viol++;
                if (!cs_n && p_cs) begin
                    if (seen && hi_run < 2 * H) gap_viol++;
                    seen = 1; frame++; bits = 0;
                end
                if (sclk && !p_sclk && !cs_n) begin
                    if (low_run < H || mosi_run < H || dc_run < H) setup_viol++;
                    acc = {acc[6:0], mosi};
                    bits++;
                    if (bits == 8) begin
                        rx_byte[rx_n] = acc; rx_dc[rx_n] = dc; rx_frame[rx_n] = frame;
                        rx_n++; bits = 0;
                    end
                end
            end
            hi_run   = cs_n ? hi_run + 1 : 0;
            low_run  = (!cs_n && !sclk) ? low_run + 1 : 0;
            mosi_run = (mosi == p_mosi) ? mosi_run + 1 : 1;
            dc_run   = (dc == p_dc) ? dc_run + 1 : 1;
            p_sclk = sclk; p_cs = cs_n; p_dc = dc; p_mosi = mosi;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int exp_frame;
        repeat (3) @(negedge clk);
        // R10: reset state
        chk(cs_n == 1'b1, "R10 cs_n", cs_n, 1);
        chk(sclk == 1'b0, "R10 sclk", sclk, 0);
        chk(dc == 1'b1, "R10 dc", dc, 1);
        chk(in_ready == 1'b1, "R10 in_ready", in_ready, 1);
        rst = 1'b0;
        repeat (4) @(negedge clk);

        for (int i = 0; i < NVEC; i++) send(VEC[i]);
        repeat (200) @(negedge clk);

        chk(rx_n == NVEC, "R5 byte count", rx_n, NVEC);
        exp_frame = 0;
        for (int i = 0; i < NVEC; i++) begin
            if (i > 0 && (VEC[i-1][9] || VEC[i-1][8] || VEC[i][9])) exp_frame++;
            chk(rx_byte[i] == VEC[i][7:0], "R5 msb-first value", rx_byte[i], VEC[i][7:0]);
            chk(rx_dc[i] == !VEC[i][9], VEC[i][9] ? "R1 dc low for command" : "R2 dc high for parameter",
                rx_dc[i], !VEC[i][9]);
            chk(rx_frame[i] == exp_frame, (i == 8) ? "R4 command after open window" : "R3 window grouping",
                rx_frame[i], exp_frame);
        end

        chk(setup_viol == 0, "R6 setup before rising edge", setup_viol, 0);
        chk(ready_viol == 0, "R7 ready low while shifting", ready_viol, 0);
        chk(gap_viol == 0, "R8 chip-select gap", gap_viol, 0);
        chk(dc_viol == 0, "R9 dc change inside window", dc_viol, 0);
        chk(idle_viol == 0, "R5 sclk idle low", idle_viol, 0);

        // R10: reset in the middle of a byte
        fork
            send({1'b1, 1'b1, 8'hC3});
        join
        repeat (5) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk(cs_n == 1'b1, "R10 abort cs_n", cs_n, 1);
        chk(sclk == 1'b0, "R10 abort sclk", sclk, 0);
        @(negedge clk);
        rst = 1'b0;
        repeat (20) @(negedge clk);
        send({1'b1, 1'b1, 8'h5A});
        repeat (100) @(negedge clk);
        chk(rx_n == NVEC + 1, "R10 partial byte dropped", rx_n, NVEC + 1);
        chk(rx_byte[NVEC] == 8'h5A, "R10 byte after abort", rx_byte[NVEC], 8'h5A);
        chk(rx_dc[NVEC] == 1'b0, "R1 dc after abort", rx_dc[NVEC], 0);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule